// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a vector of peripheral interrupt request lines and one non-maskable request, keeps per-line enable, pending and active state, and tells the processor core which request to take next. Each line carries a programmable 4-bit priority level, stored in the top nibble of a byte-wide field; a grouping register decides how many of those four bits form the preemption level, and the remaining bits act as a sub-priority that orders waiting requests without allowing preemption.

The core sees a request strobe and a request number. It acknowledges entry to a handler with a one-cycle pulse and reports handler completion with another. The controller keeps a stack of running levels so that nested handlers unwind in order and lower-priority requests resume once higher ones finish. Software reaches the state through a simple word-addressed register port with combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line is disabled, nothing is pending or active, all priority fields and the grouping register read as zero, and `irq_req_o` is low.
- R2: A line's pending bit is set by a rising edge on its `irq_i` bit (a line held high does not set it again) or by writing 1 to that bit at word address 1; writing 1 at word address 2 clears it; reading address 1 or 2 returns the pending vector with bit i for line i.
- R3: The enable register at word address 0 is read/write with bit i for line i; a disabled line may be pending but is never presented on `irq_req_o`.
- R4: Priority word 8+n holds lines 4n..4n+3, line 4n+k in bits [8k+7:8k]; only bits [8k+7:8k+4] are stored and bits [8k+3:8k] read as zero.
- R5: Among enabled pending lines the one with the smallest stored 4-bit value is presented; equal values go to the lowest line number.
- R6: The grouping register at word address 4, bits [2:0], gives g (values above 4 act as 4); the upper g bits of the 4-bit value form the preemption level and the rest the sub-priority.
- R7: `irq_ack_i` while `irq_req_o` is high clears the presented line's pending bit, sets its bit in the active register (word address 3, read only), and makes its preemption level the running level.
- R8: While a handler runs, a line is presented only when its preemption level is strictly below the running level; an equal or larger level waits.
- R9: `irq_done_i` clears the active bit of the most recently entered handler and restores the previous running level, so a waiting request may then be presented.
- R10: A rising edge on `nmi_i` pends the non-maskable request; it is presented as number NUM_LINES (8 by default) ahead of every line, preempts any running handler, and nothing preempts it.
- R11: A rising edge on a line in the same cycle as a clear-pending write to that line leaves it pending; `irq_done_i` in the same cycle as `irq_ack_i` applies the completion and ignores the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_LINES | Peripheral request lines, rising edge pends |
| nmi_i | input | 1 | Non-maskable request, rising edge pends |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_req_o | output | 1 | A request is ready to be taken |
| irq_id_o | output | ID_W | Number of the presented request (NUM_LINES for the non-maskable one) |
| irq_ack_i | input | 1 | Core entered the handler of the presented request |
| irq_done_i | input | 1 | Core finished the innermost handler |

## Verification
Two collisions are provoked on purpose: a line's rising edge arriving in exactly the cycle that software writes its clear-pending bit, and a completion pulse landing in the same cycle as an acknowledge. The first is judged by reading the pending vector afterwards and expecting the bit still set; the second by reading the active register and the presented request, expecting the finished handler gone and the presented line neither active nor cleared. Random priority and pending patterns are serviced one at a time, each presented number compared against a bench model of the ordering rules.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W = 4;
  localparam int A_EN   = 0;
  localparam int A_SETP = 1;
  localparam int A_CLRP = 2;
  localparam int A_ACT  = 3;
  localparam int A_GRP  = 4;
  localparam int A_PRIO = 8;

  typedef struct packed {
    logic              nmi;
    logic [PRIO_W-1:0] pre;
  } lvl_t;

  // upper g bits of the level are the preemption field
  function automatic logic [PRIO_W-1:0] pre_mask(input logic [2:0] grp);
    int g;
    logic [PRIO_W-1:0] m;
    g = (int'(grp) > PRIO_W) ? PRIO_W : int'(grp);
    m = '0;
    for (int b = 0; b < PRIO_W; b++)
      if (b >= PRIO_W - g) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  input  logic [N-1:0]               hw_set_i,
  input  logic [N-1:0]               ack_clr_i,
  input  logic [N-1:0]               act_i,
  output logic [N-1:0]               en_o,
  output logic [N-1:0]               pend_o,
  output logic [N-1:0][PRIO_W-1:0]   prio_o,
  output logic [2:0]                 grp_o
);
  localparam int NWORD = N / 4;

  logic [N-1:0]             en_q, pend_q, set_m, clr_m;
  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic [2:0]               grp_q;

  assign set_m = (we_i && addr_i == ADDR_W'(A_SETP)) ? wdata_i[N-1:0] : '0;
  assign clr_m = (we_i && addr_i == ADDR_W'(A_CLRP)) ? wdata_i[N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      grp_q  <= '0;
    end else begin
      // sets win over clears so a fresh event is never dropped
      pend_q <= (pend_q & ~clr_m & ~ack_clr_i) | set_m | hw_set_i;
      if (we_i && addr_i == ADDR_W'(A_EN))  en_q  <= wdata_i[N-1:0];
      if (we_i && addr_i == ADDR_W'(A_GRP)) grp_q <= wdata_i[2:0];
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    for (genvar k = 0; k < 4; k++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prio_q[4*w+k] <= '0;
        else if (we_i && addr_i == ADDR_W'(A_PRIO + w))
          prio_q[4*w+k] <= wdata_i[8*k+4 +: PRIO_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      A_EN:   rdata_o[N-1:0] = en_q;
      A_SETP: rdata_o[N-1:0] = pend_q;
      A_CLRP: rdata_o[N-1:0] = pend_q;
      A_ACT:  rdata_o[N-1:0] = act_i;
      A_GRP:  rdata_o[2:0]   = grp_q;
      default: begin
        for (int w = 0; w < NWORD; w++)
          if (int'(addr_i) == A_PRIO + w)
            for (int k = 0; k < 4; k++)
              rdata_o[8*k+4 +: PRIO_W] = prio_q[4*w+k];
      end
    endcase
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign prio_o = prio_q;
  assign grp_o  = grp_q;

  assert_clr_applied_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_m != '0) |=> ((pend_q & $past(clr_m) & ~$past(set_m | hw_set_i)) == '0));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int N    = 8,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     valid_o,
  output logic [ID_W-1:0]          id_o,
  output logic [PRIO_W-1:0]        prio_o
);
  // strict compare keeps the lowest index on equal values
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = 17,
  parameter int ID_W  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  lvl_t            push_lvl_i,
  input  logic            pop_i,
  output logic            empty_o,
  output logic            full_o,
  output logic [ID_W-1:0] top_id_o,
  output lvl_t            top_lvl_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0] id_q  [DEPTH];
  lvl_t            lvl_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_ix;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_ix  = empty_o ? '0 : cnt_q - 1'b1;
  assign top_id_o  = id_q[top_ix];
  assign top_lvl_o = lvl_q[top_ix];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[d]  <= '0;
        lvl_q[d] <= '0;
      end else if (push_i && !full_o && cnt_q == CNT_W'(d)) begin
        id_q[d]  <= push_id_i;
        lvl_q[d] <= push_lvl_i;
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_unwinds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 4,
  parameter int ID_W      = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 nmi_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 irq_req_o,
  output logic [ID_W-1:0]      irq_id_o,
  input  logic                 irq_ack_i,
  input  logic                 irq_done_i
);
  localparam int N     = NUM_LINES;
  localparam int DEPTH = (1 << PRIO_W) + 1;

  logic [N-1:0]             irq_rise, en, pend, cand, ack_clr, act_q;
  logic [N-1:0][PRIO_W-1:0] prio;
  logic [2:0]               grp;
  logic                     nmi_rise, nmi_pend_q, nmi_cand;
  logic                     win_valid, irq_ok, push, pop;
  logic [ID_W-1:0]          win_id, top_id;
  logic [PRIO_W-1:0]        win_prio, win_pre;
  logic                     st_empty, st_full, top_nmi;
  lvl_t                     top_lvl, push_lvl;

  irqc_edge #(.W(N)) u_irq_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(irq_i), .rise_o(irq_rise)
  );

  irqc_edge #(.W(1)) u_nmi_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(nmi_i), .rise_o(nmi_rise)
  );

  irqc_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .hw_set_i(irq_rise), .ack_clr_i(ack_clr), .act_i(act_q),
    .en_o(en), .pend_o(pend), .prio_o(prio), .grp_o(grp)
  );

  assign cand = en & pend;

  irqc_arb #(.N(N), .ID_W(ID_W)) u_arb (
    .cand_i(cand), .prio_i(prio),
    .valid_o(win_valid), .id_o(win_id), .prio_o(win_prio)
  );

  irqc_stack #(.DEPTH(DEPTH), .ID_W(ID_W)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .push_id_i(irq_id_o), .push_lvl_i(push_lvl), .pop_i(pop),
    .empty_o(st_empty), .full_o(st_full), .top_id_o(top_id), .top_lvl_o(top_lvl)
  );

  assign top_nmi  = !st_empty && top_lvl.nmi;
  assign nmi_cand = nmi_pend_q && !top_nmi;
  assign win_pre  = win_prio & pre_mask(grp);
  assign irq_ok   = win_valid && (st_empty || (!top_nmi && win_pre < top_lvl.pre));

  assign irq_req_o = nmi_cand || irq_ok;
  assign irq_id_o  = nmi_cand ? ID_W'(N) : win_id;

  // completion wins over a coincident acknowledge
  assign push = irq_ack_i && irq_req_o && !irq_done_i;
  assign pop  = irq_done_i && !st_empty;

  assign push_lvl.nmi = nmi_cand;
  assign push_lvl.pre = nmi_cand ? '0 : win_pre;

  always_comb begin
    ack_clr = '0;
    if (push && !nmi_cand) ack_clr[win_id] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_pend_q <= (nmi_pend_q && !(push && nmi_cand)) || nmi_rise;
      if (push && !nmi_cand) act_q[win_id] <= 1'b1;
      if (pop && !top_lvl.nmi && int'(top_id) < N) act_q[top_id] <= 1'b0;
    end
  end

  assert_req_only_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && int'(irq_id_o) < N) |-> (en[irq_id_o] && pend[irq_id_o]));
  assert_ack_sets_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !nmi_cand) |=> act_q[$past(win_id)]);
  assert_nest_strict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !nmi_cand && !st_empty) |-> (!top_lvl.nmi && win_pre < top_lvl.pre));
  assert_nmi_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !top_nmi) |-> (irq_req_o && int'(irq_id_o) == N));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          nmi = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          req;
  logic [IW-1:0] id;
  logic          ack = 1'b0;
  logic          done = 1'b0;

  int ntot = 0;
  int nbad = 0;
  bit finished = 0;
  logic [3:0] m_prio [N];

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_id_o(id), .irq_ack_i(ack), .irq_done_i(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq[line] = 1'b1;
    @(negedge clk); irq[line] = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic set_prio(input int line, input logic [3:0] v);
    logic [31:0] w;
    int base;
    m_prio[line] = v;
    base = (line / 4) * 4;
    w = '0;
    for (int k = 0; k < 4; k++) w[8*k+4 +: 4] = m_prio[base+k];
    wr(8 + line / 4, w);
  endtask

  function automatic int exp_win(input logic [N-1:0] c);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (c[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    return best;
  endfunction

  task automatic chk_req(input string tag, input bit exp_req, input int exp_id);
    chk({tag, " req"}, 32'(req), 32'(exp_req));
    if (exp_req) chk({tag, " id"}, 32'(id), 32'(exp_id));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ntot++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a7e));
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 enable", 0, 0);
    rdchk("R1 pending", 1, 0);
    rdchk("R1 active", 3, 0);
    rdchk("R1 group", 4, 0);
    rdchk("R1 prio0", 8, 0);
    rdchk("R1 prio1", 9, 0);
    chk("R1 req", 32'(req), 0);

    // R4 byte layout and low nibble
    wr(8, 32'hFFFF_FFFF);
    rdchk("R4 low nibble zero", 8, 32'hF0F0_F0F0);
    wr(9, 32'h1234_5678);
    rdchk("R4 upper nibbles kept", 9, 32'h1030_5070);
    wr(8, 0); wr(9, 0);

    // R3 disabled line pends but is not presented
    pulse(2);
    rdchk("R3 pending while disabled", 1, 32'h04);
    chk("R3 no req when disabled", 32'(req), 0);
    wr(0, 32'hFF);
    rdchk("R3 enable readback", 0, 32'hFF);
    chk_req("R3 enabled presents", 1, 2);
    wr(2, 32'h04);
    rdchk("R2 clear pending", 1, 0);

    // R2 level held does not re-pend
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk);
    rdchk("R2 edge pends", 1, 32'h08);
    wr(2, 32'h08);
    repeat (2) @(negedge clk);
    rdchk("R2 held level no re-pend", 1, 0);
    irq[3] = 1'b0;
    @(negedge clk);

    // R11 edge and clear-pending write in the same cycle
    @(negedge clk);
    irq[3] = 1'b1; we = 1'b1; addr = AW'(2); wdata = 32'h08;
    @(negedge clk);
    we = 1'b0;
    rdchk("R11 edge beats clear", 1, 32'h08);
    irq[3] = 1'b0;
    wr(2, 32'hFF);

    // R5 tie goes to lower line
    set_prio(0, 4'h3); set_prio(6, 4'h3); set_prio(5, 4'h9);
    wr(1, 32'h61);
    chk_req("R5 tie lower index", 1, 0);
    set_prio(0, 4'hA);
    chk_req("R5 smaller value wins", 1, 6);
    wr(2, 32'hFF);

    // R7/R8/R9 nesting with g=4
    wr(4, 4);
    set_prio(2, 4'h8); set_prio(5, 4'h4); set_prio(1, 4'hC);
    pulse(2);
    chk_req("R7 first request", 1, 2);
    do_ack();
    rdchk("R7 active set", 3, 32'h04);
    rdchk("R7 pending cleared", 1, 0);
    pulse(1);
    chk("R8 lower level waits", 32'(req), 0);
    pulse(5);
    chk_req("R8 higher preempts", 1, 5);
    do_ack();
    rdchk("R8 nested active", 3, 32'h24);
    do_done();
    rdchk("R9 inner cleared", 3, 32'h04);
    chk("R9 running restored", 32'(req), 0);
    do_done();
    rdchk("R9 outer cleared", 3, 0);
    chk_req("R9 waiting presented", 1, 1);

    // R11 done coincident with ack: ack ignored
    do_ack();
    @(negedge clk); ack = 1'b1; done = 1'b1;
    pulse(5);
    @(negedge clk); ack = 1'b0; done = 1'b0;
    rdchk("R11 done applied", 3, 0);
    chk_req("R11 ack ignored", 1, 5);
    do_ack(); do_done();

    // R6 sub-priority with g=1
    wr(4, 1);
    set_prio(3, 4'h2); set_prio(4, 4'h6); set_prio(7, 4'h9);
    wr(1, 32'h18);
    chk_req("R6 sub order", 1, 3);
    do_ack();
    chk("R6 same group no preempt", 32'(req), 0);
    do_done();
    chk_req("R6 next after done", 1, 4);
    do_ack(); do_done();
    pulse(7);
    do_ack();
    pulse(4);
    chk_req("R6 preempt group differs", 1, 4);
    do_ack(); do_done(); do_done();
    // g above 4 behaves as 4
    wr(4, 7);
    pulse(7); do_ack();
    pulse(4);
    chk_req("R6 group saturates", 1, 4);
    do_ack(); do_done(); do_done();
    // g=0 never preempts
    wr(4, 0);
    pulse(7); do_ack();
    pulse(5);
    chk("R6 g0 no preempt", 32'(req), 0);
    do_done();
    chk_req("R6 g0 after done", 1, 5);
    do_ack(); do_done();

    // R10 non-maskable
    wr(4, 4);
    set_prio(0, 4'h0);
    pulse(7); do_ack();
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    chk_req("R10 nmi preempts", 1, N);
    do_ack();
    pulse(0);
    chk("R10 nothing preempts nmi", 32'(req), 0);
    rdchk("R10 line pending", 1, 32'h01);
    do_done();
    chk_req("R10 after nmi", 1, 0);
    do_ack(); do_done(); do_done();
    rdchk("R9 all unwound", 3, 0);

    // random servicing against model
    for (int r = 0; r < 12; r++) begin
      logic [N-1:0] en_m, pd_m;
      for (int i = 0; i < N; i++) set_prio(i, 4'($urandom));
      wr(4, $urandom % 5);
      en_m = N'($urandom);
      pd_m = N'($urandom);
      wr(0, 32'(en_m));
      wr(1, 32'(pd_m));
      for (int s = 0; s < N; s++) begin
        int w;
        w = exp_win(en_m & pd_m);
        if (w < 0) begin
          chk("R3 random idle", 32'(req), 0);
          break;
        end
        chk_req("R5 random order", 1, w);
        do_ack();
        pd_m[w] = 1'b0;
        rdchk("R7 random pending", 1, 32'(pd_m));
        do_done();
      end
      wr(2, 32'hFF);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule